// File: doc/BRIEF.md
# Card host status and data-timeout unit

This unit follows a memory-card host controller through each command sequence. It turns event strobes from the controller into a packed read-only status byte. That byte carries a busy bit plus two sticky FIFO-level bits. Each FIFO bit is captured only in its own transfer direction, and each is released either by its own software strobe or by the end of the sequence.

The unit also watches the data phase for stalls. A 16-bit programmable limit, multiplied by a fixed prescale factor (10,000 by default), sets the longest gap allowed between data words. If no word arrives within that gap while the data phase is still active, a timeout flag is raised. The limit is held in a register that can be written and read back. The status byte is read through the same small register port.

Top module: `card_stat_tmo`

## Requirements
- R1: The timeout limit register is TMO_W (16) bits wide and resets to all ones. It is written and read at address 0 of the register port.
- R2: A command-start strobe sets the busy bit (status bit 7). The bit stays 1 until sequence-complete or abort clears it. A clear in the same cycle as a start wins.
- R3: An abort strobe forces the busy bit to 0 on the following clock edge.
- R4: Status bit 6 (FIFO full) is set when busy is 1, the receive direction is active and the FIFO-full level is high. A full level during transmit does not set it.
- R5: The FIFO-full bit is cleared by the read-continue strobe or by sequence-complete. A clear beats a set in the same cycle, and the bit sets again on the next cycle if the condition still holds.
- R6: Status bit 5 (FIFO empty) is set when busy is 1, the transmit direction is active and the FIFO-empty level is high. An empty level during receive does not set it.
- R7: The FIFO-empty bit is cleared by the data-enable strobe or by sequence-complete. The clear has priority over the set.
- R8: The status byte reads at address 1 as the upper half zero, bits 4 to 0 zero, and all bits 0 after reset. A write to address 1 changes nothing.
- R9: A data phase is active when busy is 1 and receive or transmit is active. With limit N, the timeout flag is low N×PRESCALE clock edges after the first active edge and high on the next edge, provided no word is transferred.
- R10: A word-transfer strobe during the data phase restarts the countdown from the full limit.
- R11: The timeout flag is cleared by command-start, sequence-complete or abort. It rises only while a data phase is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_start_i | input | 1 | Command sequence start strobe |
| seq_done_i | input | 1 | Command sequence complete strobe |
| abort_i | input | 1 | Command abort strobe |
| rx_i | input | 1 | Receive direction active |
| tx_i | input | 1 | Transmit direction active |
| fifo_full_i | input | 1 | FIFO full level |
| fifo_empty_i | input | 1 | FIFO empty level |
| rd_cont_i | input | 1 | Read-continue strobe, clears FIFO-full bit |
| data_en_i | input | 1 | Data-enable strobe, clears FIFO-empty bit |
| word_xfer_i | input | 1 | One data word moved |
| reg_we_i | input | 1 | Register write enable |
| reg_addr_i | input | 1 | Register address: 0 limit, 1 status |
| reg_wdata_i | input | TMO_W | Register write data |
| reg_rdata_o | output | TMO_W | Register read data |
| status_o | output | 8 | Packed status byte |
| dto_o | output | 1 | Data timeout flag |

## Verification
The bench builds the unit with PRESCALE set to 4 in place of 10,000 and keeps TMO_W at 16. With a small written limit, both the full expiry and a restart in the middle of the countdown happen within a few dozen cycles, so the timeout edge can be checked to the exact cycle. The reset value of the limit register is still checked at its full 16-bit width.

// File: rtl/card_stat_pkg.sv
package card_stat_pkg;
  localparam int STAT_W    = 8;
  localparam int BIT_BUSY  = 7;
  localparam int BIT_FULL  = 6;
  localparam int BIT_EMPTY = 5;
  localparam int N_FLAGS   = 3;

  typedef enum logic [0:0] {
    ADDR_TMO  = 1'b0,
    ADDR_STAT = 1'b1
  } reg_addr_e;

  // flag index in set/clear vectors
  localparam int F_BUSY  = 0;
  localparam int F_FULL  = 1;
  localparam int F_EMPTY = 2;
endpackage

// File: rtl/sticky_flag.sv
module sticky_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= 1'b0;
    else if (clr_i) q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;
  end
endmodule

// File: rtl/tmo_counter.sv
module tmo_counter #(
  parameter int CNT_W    = 16,
  parameter int PRESCALE = 10000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             active_i,
  input  logic             restart_i,
  input  logic [CNT_W-1:0] limit_i,
  input  logic             flag_clr_i,
  output logic             expired_o
);
  localparam int PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PRE_W-1:0] PRE_MAX = PRE_W'(PRESCALE - 1);

  logic             active_q;
  logic [PRE_W-1:0] pre_q;
  logic [CNT_W-1:0] cnt_q;
  logic             load;
  logic             tick;

  assign load = active_i && (!active_q || restart_i);
  assign tick = (pre_q == PRE_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) active_q <= 1'b0;
    else         active_q <= active_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else if (load) begin
      pre_q <= '0;
      cnt_q <= limit_i;
    end else if (active_i) begin
      if (tick) begin
        pre_q <= '0;
        if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
      end else begin
        pre_q <= pre_q + 1'b1;
      end
    end else begin
      pre_q <= '0;
    end
  end

  // expiry is seen one edge after the count reaches zero
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                  expired_o <= 1'b0;
    else if (flag_clr_i)                          expired_o <= 1'b0;
    else if (active_i && !load && cnt_q == '0)    expired_o <= 1'b1;
  end
endmodule

// File: rtl/card_stat_regs.sv
module card_stat_regs
  import card_stat_pkg::*;
#(
  parameter int TMO_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              addr_i,
  input  logic [TMO_W-1:0]  wdata_i,
  input  logic [STAT_W-1:0] status_i,
  output logic [TMO_W-1:0]  limit_o,
  output logic [TMO_W-1:0]  rdata_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          limit_o <= '1;
    else if (we_i && addr_i == ADDR_TMO)  limit_o <= wdata_i;
  end

  always_comb begin
    if (addr_i == ADDR_TMO) rdata_o = limit_o;
    else                    rdata_o = {{(TMO_W-STAT_W){1'b0}}, status_i};
  end
endmodule

// File: rtl/card_stat_tmo.sv
module card_stat_tmo
  import card_stat_pkg::*;
#(
  parameter int TMO_W    = 16,
  parameter int PRESCALE = 10000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_start_i,
  input  logic              seq_done_i,
  input  logic              abort_i,
  input  logic              rx_i,
  input  logic              tx_i,
  input  logic              fifo_full_i,
  input  logic              fifo_empty_i,
  input  logic              rd_cont_i,
  input  logic              data_en_i,
  input  logic              word_xfer_i,
  input  logic              reg_we_i,
  input  logic              reg_addr_i,
  input  logic [TMO_W-1:0]  reg_wdata_i,
  output logic [TMO_W-1:0]  reg_rdata_o,
  output logic [STAT_W-1:0] status_o,
  output logic              dto_o
);
  logic [N_FLAGS-1:0] flag_set, flag_clr, flag_q;
  logic [TMO_W-1:0]   tmo_q;
  logic               busy, data_act;

  assign busy = flag_q[F_BUSY];

  assign flag_set[F_BUSY]  = cmd_start_i;
  assign flag_clr[F_BUSY]  = seq_done_i | abort_i;
  assign flag_set[F_FULL]  = busy & rx_i & fifo_full_i;
  assign flag_clr[F_FULL]  = rd_cont_i | seq_done_i;
  assign flag_set[F_EMPTY] = busy & tx_i & fifo_empty_i;
  assign flag_clr[F_EMPTY] = data_en_i | seq_done_i;

  for (genvar g = 0; g < N_FLAGS; g++) begin : g_flag
    sticky_flag u_flag (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (flag_set[g]),
      .clr_i  (flag_clr[g]),
      .q_o    (flag_q[g])
    );
  end

  always_comb begin
    status_o            = '0;
    status_o[BIT_BUSY]  = flag_q[F_BUSY];
    status_o[BIT_FULL]  = flag_q[F_FULL];
    status_o[BIT_EMPTY] = flag_q[F_EMPTY];
  end

  assign data_act = busy & (rx_i | tx_i);

  tmo_counter #(
    .CNT_W    (TMO_W),
    .PRESCALE (PRESCALE)
  ) u_tmo (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .active_i   (data_act),
    .restart_i  (word_xfer_i),
    .limit_i    (tmo_q),
    .flag_clr_i (cmd_start_i | seq_done_i | abort_i),
    .expired_o  (dto_o)
  );

  card_stat_regs #(.TMO_W(TMO_W)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (reg_we_i),
    .addr_i   (reg_addr_i),
    .wdata_i  (reg_wdata_i),
    .status_i (status_o),
    .limit_o  (tmo_q),
    .rdata_o  (reg_rdata_o)
  );
endmodule

// File: rtl/card_stat_tmo_chk.sv
module card_stat_tmo_chk #(
  parameter int TMO_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cmd_start_i,
  input logic             seq_done_i,
  input logic             abort_i,
  input logic             rx_i,
  input logic             tx_i,
  input logic             fifo_full_i,
  input logic             fifo_empty_i,
  input logic             rd_cont_i,
  input logic             data_en_i,
  input logic             reg_we_i,
  input logic             reg_addr_i,
  input logic [TMO_W-1:0] reg_wdata_i,
  input logic [TMO_W-1:0] tmo_q,
  input logic [7:0]       status_o,
  input logic             dto_o
);
  assert_tmo_write_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == 1'b0) |=> tmo_q == $past(reg_wdata_i));

  assert_start_busy_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_start_i && !seq_done_i && !abort_i) |=> status_o[7]);

  assert_abort_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> !status_o[7]);

  assert_full_rx_only_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_o[6]) |-> $past(rx_i && fifo_full_i));

  assert_full_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_cont_i || seq_done_i) |=> !status_o[6]);

  assert_empty_tx_only_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_o[5]) |-> $past(tx_i && fifo_empty_i));

  assert_empty_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_en_i || seq_done_i) |=> !status_o[5]);

  assert_unused_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[4:0] == 5'b0);

  assert_dto_in_phase_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dto_o) |-> $past(status_o[7] && (rx_i || tx_i)));

  assert_dto_clear_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_start_i || seq_done_i || abort_i) |=> !dto_o);
endmodule

bind card_stat_tmo card_stat_tmo_chk #(.TMO_W(TMO_W)) chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cmd_start_i  (cmd_start_i),
  .seq_done_i   (seq_done_i),
  .abort_i      (abort_i),
  .rx_i         (rx_i),
  .tx_i         (tx_i),
  .fifo_full_i  (fifo_full_i),
  .fifo_empty_i (fifo_empty_i),
  .rd_cont_i    (rd_cont_i),
  .data_en_i    (data_en_i),
  .reg_we_i     (reg_we_i),
  .reg_addr_i   (reg_addr_i),
  .reg_wdata_i  (reg_wdata_i),
  .tmo_q        (tmo_q),
  .status_o     (status_o),
  .dto_o        (dto_o)
);

// File: tb/card_stat_tmo_tb_top.sv
module card_stat_tmo_tb_top;
  localparam int TMO_W    = 16;
  localparam int PRESCALE = 4;
  localparam int SRC_STAT = 0;
  localparam int SRC_RD   = 1;
  localparam int SRC_DTO  = 2;

  typedef struct {
    int          src;
    logic [15:0] exp;
    string       tag;
  } item_t;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic cmd_start_i = 0, seq_done_i = 0, abort_i = 0, rx_i = 0, tx_i = 0;
  logic fifo_full_i = 0, fifo_empty_i = 0, rd_cont_i = 0, data_en_i = 0, word_xfer_i = 0;
  logic reg_we_i = 0, reg_addr_i = 0;
  logic [TMO_W-1:0] reg_wdata_i = '0;
  logic [TMO_W-1:0] reg_rdata_o;
  logic [7:0]       status_o;
  logic             dto_o;

  int checks = 0, errors = 0;
  bit done = 0;
  item_t q[$];

  always #10 clk = ~clk;

  card_stat_tmo #(.TMO_W(TMO_W), .PRESCALE(PRESCALE)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .cmd_start_i(cmd_start_i), .seq_done_i(seq_done_i),
    .abort_i(abort_i), .rx_i(rx_i), .tx_i(tx_i), .fifo_full_i(fifo_full_i),
    .fifo_empty_i(fifo_empty_i), .rd_cont_i(rd_cont_i), .data_en_i(data_en_i),
    .word_xfer_i(word_xfer_i), .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o), .status_o(status_o), .dto_o(dto_o)
  );

  // monitor: compares queued expectations mid-cycle
  initial begin
    forever begin
      @(negedge clk);
      while (q.size() > 0) begin
        item_t it;
        logic [15:0] got;
        it = q.pop_front();
        case (it.src)
          SRC_STAT: got = {8'h00, status_o};
          SRC_RD:   got = reg_rdata_o;
          default:  got = {15'h0, dto_o};
        endcase
        checks++;
        if (got !== it.exp) begin
          errors++;
          $display("FAIL %s actual=%h expected=%h", it.tag, got, it.exp);
        end
      end
    end
  end

  task automatic cyc();
    @(posedge clk); #2;
  endtask

  task automatic expect_val(input int src, input logic [15:0] exp, input string tag);
    item_t it;
    it.src = src; it.exp = exp; it.tag = tag;
    q.push_back(it);
    @(negedge clk); #1;
  endtask

  task automatic pulse_start();
    cmd_start_i = 1; cyc(); cmd_start_i = 0;
  endtask

  task automatic pulse_done();
    seq_done_i = 1; cyc(); seq_done_i = 0;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_ni = 1;
    cyc();
    // reset state
    reg_addr_i = 0; expect_val(SRC_RD, 16'hFFFF, "R1 limit reset");
    reg_addr_i = 1; expect_val(SRC_RD, 16'h0000, "R8 status reset");

    // limit write/read
    reg_we_i = 1; reg_addr_i = 0; reg_wdata_i = 16'd3; cyc(); reg_we_i = 0;
    expect_val(SRC_RD, 16'd3, "R1 limit readback");

    // busy set, start vs done collision
    pulse_start();
    expect_val(SRC_STAT, 16'h0080, "R2 busy set");
    cmd_start_i = 1; seq_done_i = 1; cyc(); cmd_start_i = 0; seq_done_i = 0;
    expect_val(SRC_STAT, 16'h0000, "R2 clear wins");

    // abort
    pulse_start();
    abort_i = 1; cyc(); abort_i = 0;
    expect_val(SRC_STAT, 16'h0000, "R3 abort clears busy");

    // write to status ignored
    pulse_start();
    reg_we_i = 1; reg_addr_i = 1; reg_wdata_i = 16'hFFFF; cyc(); reg_we_i = 0;
    expect_val(SRC_STAT, 16'h0080, "R8 status write ignored");
    reg_addr_i = 0; expect_val(SRC_RD, 16'd3, "R8 limit untouched");

    // full not set during transmit
    tx_i = 1; fifo_full_i = 1; cyc();
    expect_val(SRC_STAT, 16'h0080, "R4 full ignored in tx");
    // empty set during transmit
    fifo_empty_i = 1; cyc();
    expect_val(SRC_STAT, 16'h00A0, "R6 empty set in tx");
    // data_en clears, re-set next cycle
    data_en_i = 1; cyc(); data_en_i = 0;
    expect_val(SRC_STAT, 16'h0080, "R7 data_en clears");
    cyc();
    expect_val(SRC_STAT, 16'h00A0, "R7 empty re-sets");
    fifo_empty_i = 0; tx_i = 0; fifo_full_i = 0;
    pulse_done();
    expect_val(SRC_STAT, 16'h0000, "R7 done clears empty");

    // full in receive
    pulse_start();
    rx_i = 1; fifo_empty_i = 1; fifo_full_i = 1; cyc();
    expect_val(SRC_STAT, 16'h00C0, "R4 full set, R6 empty ignored in rx");
    rd_cont_i = 1; cyc(); rd_cont_i = 0;
    expect_val(SRC_STAT, 16'h0080, "R5 rd_cont clear wins");
    cyc();
    expect_val(SRC_STAT, 16'h00C0, "R5 full re-sets");
    fifo_full_i = 0; fifo_empty_i = 0; rx_i = 0;
    pulse_done();
    expect_val(SRC_STAT, 16'h0000, "R5 done clears full");

    // timeout: limit 3, prescale 4 -> expiry after 13 edges
    pulse_start();
    rx_i = 1;
    repeat (13) @(posedge clk);
    expect_val(SRC_DTO, 16'h0, "R9 not yet expired");
    @(posedge clk);
    expect_val(SRC_DTO, 16'h1, "R9 expired on time");
    #1;
    rx_i = 0;
    pulse_done();
    expect_val(SRC_DTO, 16'h0, "R11 done clears dto");

    // restart by word transfer
    pulse_start();
    rx_i = 1;
    repeat (8) @(posedge clk);
    #2 word_xfer_i = 1; cyc(); word_xfer_i = 0;
    repeat (12) @(posedge clk);
    expect_val(SRC_DTO, 16'h0, "R10 restart delays expiry");
    @(posedge clk);
    expect_val(SRC_DTO, 16'h1, "R10 expired after restart");
    #1;
    abort_i = 1; cyc(); abort_i = 0;
    expect_val(SRC_DTO, 16'h0, "R11 abort clears dto");

    // no data phase -> no timeout
    rx_i = 0;
    repeat (20) @(posedge clk);
    expect_val(SRC_DTO, 16'h0, "R11 idle no dto");

    done = 1;
    cyc();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule